// File: doc/BRIEF.md
# Priority-Based Clock Reference Selector

The block picks one clock reference out of six candidates. Every candidate arrives with a valid flag, which some upstream activity monitor drives, and a 4-bit priority. In automatic operation the valid candidate with the best priority drives the output. Candidates that share a priority are served in the order they became valid. A 4-bit force code can pin the choice to one particular input. Software can choose one of two restoration policies for a higher-ranked input that comes back:
- **Revertive:** the selector switches to the returning input.
- **Non-revertive:** the selector holds the current source for as long as that source stays valid.

Each decision is registered, so the output reflects the inputs one clock later. The block reports the chosen index and a flag that says whether that choice is live. When no candidate qualifies, the live flag drops and the index holds its last value, which signals holdover to the clock loop that follows.

An input that becomes valid without being chosen sets a sticky per-input event bit. The unmasked event bits are ORed into one interrupt line. Software clears event bits by writing ones to a clear vector.

Top module: `ref_selector`

## Requirements
- R1: After reset, sel_valid is 0, sel_idx is 0, reval_flag is all zeros and irq is 0.
- R2: In automatic mode the next sel_idx is the valid input with the numerically smallest nonzero priority, and sel_valid becomes 1. The decision appears one clock after the inputs. Input i's priority is taken from ref_prio bits [4i+3:4i].
- R3: An input whose priority is 0 is never picked in automatic mode, even when it is valid.
- R4: When the selected input goes invalid, the next cycle selects the best remaining candidate. This holds in both restoration modes, and also when a better input becomes valid in that same cycle.
- R5: With revertive = 0 in automatic mode, a selected input that stays valid with nonzero priority is kept, whatever other inputs do.
- R6: With revertive = 1, a valid input whose priority is strictly better than the selected one takes over on the next cycle.
- R7: force_code values 0 and 15 mean automatic selection. A value k from 1 to 6 forces sel_idx to k-1, and sel_valid then follows that input's valid flag. Values 7 to 14 also mean automatic selection.
- R8: When no input qualifies in automatic mode, sel_valid goes to 0 and sel_idx keeps its previous value.
- R9: A 0-to-1 change on ref_valid[i] sets reval_flag[i] unless that same cycle's decision selects input i. A set bit stays set until a cycle in which reval_clr[i] is 1. If a set and a clear land in the same cycle, the set wins.
- R10: irq is 1 exactly when some reval_flag bit is 1 and its reval_mask bit is 0.
- R11: Among equal-priority candidates the selector picks the one that has been valid longest, and it does not leave the current one for an equal peer in either mode. An input that returns joins behind its peers. Among inputs that become valid in the same cycle, the lower index counts as older.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_valid | input | 6 | Per-input valid flag from the activity monitor |
| ref_prio | input | 24 | Packed 4-bit priorities, input i at bits [4i+3:4i]; 0 excludes the input |
| revertive | input | 1 | 1 = revertive restoration, 0 = non-revertive |
| force_code | input | 4 | Force code; 0 or 15 (or 7 to 14) = automatic, k = 1..6 forces input k-1 |
| reval_mask | input | 6 | Per-input interrupt mask, 1 = masked |
| reval_clr | input | 6 | Per-input write-one clear of the event bits |
| sel_idx | output | 3 | Index of the selected input |
| sel_valid | output | 1 | Selected input is live (0 = holdover) |
| reval_flag | output | 6 | Sticky re-validation event bits |
| irq | output | 1 | OR of unmasked event bits |

## Verification
The critical collision happens in non-revertive mode: the selected input fails in the same cycle that a better-ranked input comes back. The bench provokes this by changing both valid bits in a single drive. It expects the returning input to be selected on the next clock, with no event bit raised for it, because the failover decision takes precedence over the hold policy. A second collision checks a re-validation event landing together with a software clear of the same bit, and the bench expects the bit to remain set.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;

    // Reason behind a selection decision in one cycle.
    typedef enum logic [1:0] {
        DEC_FORCED = 2'd0,
        DEC_KEEP   = 2'd1,
        DEC_BEST   = 2'd2,
        DEC_HOLD   = 2'd3
    } sel_dec_e;

endpackage

// File: rtl/ref_order_track.sv
// Keeps an arrival rank per valid input: 0 = oldest. Ranks of inputs that
// stay valid close up when older inputs drop; new arrivals go to the back.
module ref_order_track #(
    parameter int N_REF  = 6,
    parameter int RANK_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_REF-1:0]               valid,
    output logic [N_REF-1:0]               rise,
    output logic [N_REF-1:0][RANK_W-1:0]   rank_nxt
);

    typedef struct packed {
        logic [N_REF-1:0]             prev;
        logic [N_REF-1:0][RANK_W-1:0] rank;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [N_REF-1:0] stay, fall;

    always_comb begin
        int n_stay;
        int cnt;
        trk_d = trk_q;
        stay  = trk_q.prev & valid;
        fall  = trk_q.prev & ~valid;
        rise  = ~trk_q.prev & valid;
        n_stay = 0;
        for (int i = 0; i < N_REF; i++) begin
            if (stay[i]) n_stay++;
        end
        for (int j = 0; j < N_REF; j++) begin
            cnt = 0;
            if (stay[j]) begin
                for (int f = 0; f < N_REF; f++) begin
                    if (fall[f] && (trk_q.rank[f] < trk_q.rank[j])) cnt++;
                end
                trk_d.rank[j] = trk_q.rank[j] - RANK_W'(cnt);
            end else if (rise[j]) begin
                cnt = n_stay;
                for (int k = 0; k < j; k++) begin
                    if (rise[k]) cnt++;
                end
                trk_d.rank[j] = RANK_W'(cnt);
            end else begin
                trk_d.rank[j] = '0;
            end
        end
        trk_d.prev = valid;
        rank_nxt   = trk_d.rank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

endmodule

// File: rtl/ref_best_pick.sv
// Finds the eligible input with the smallest priority, oldest arrival first.
module ref_best_pick #(
    parameter int N_REF  = 6,
    parameter int PRIO_W = 4,
    parameter int RANK_W = 3,
    parameter int IDX_W  = 3
) (
    input  logic [N_REF-1:0]               valid,
    input  logic [N_REF-1:0][PRIO_W-1:0]   prio,
    input  logic [N_REF-1:0][RANK_W-1:0]   rank,
    output logic                           found,
    output logic [IDX_W-1:0]               best_idx,
    output logic [PRIO_W-1:0]              best_prio
);

    always_comb begin
        logic [RANK_W-1:0] best_rank;
        found     = 1'b0;
        best_idx  = '0;
        best_prio = '0;
        best_rank = '0;
        for (int i = 0; i < N_REF; i++) begin
            if (valid[i] && (prio[i] != '0)) begin
                if (!found || (prio[i] < best_prio) ||
                    ((prio[i] == best_prio) && (rank[i] < best_rank))) begin
                    found     = 1'b1;
                    best_idx  = IDX_W'(i);
                    best_prio = prio[i];
                    best_rank = rank[i];
                end
            end
        end
    end

endmodule

// File: rtl/ref_selector.sv
module ref_selector
    import ref_sel_pkg::*;
#(
    parameter int N_REF   = 6,
    parameter int PRIO_W  = 4,
    parameter int FORCE_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_REF-1:0]          ref_valid,
    input  logic [N_REF*PRIO_W-1:0]   ref_prio,
    input  logic                      revertive,
    input  logic [FORCE_W-1:0]        force_code,
    input  logic [N_REF-1:0]          reval_mask,
    input  logic [N_REF-1:0]          reval_clr,
    output logic [$clog2(N_REF)-1:0]  sel_idx,
    output logic                      sel_valid,
    output logic [N_REF-1:0]          reval_flag,
    output logic                      irq
);

    localparam int IDX_W  = $clog2(N_REF);
    localparam int RANK_W = $clog2(N_REF);

    typedef struct packed {
        logic [IDX_W-1:0] sel_idx;
        logic             sel_valid;
        logic [N_REF-1:0] flag;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [N_REF-1:0][PRIO_W-1:0] prio_a;
    logic [N_REF-1:0][RANK_W-1:0] rank_nxt;
    logic [N_REF-1:0]             rise;
    logic                         found;
    logic [IDX_W-1:0]             best_idx;
    logic [PRIO_W-1:0]            best_prio;

    for (genvar g = 0; g < N_REF; g++) begin : g_unpack
        assign prio_a[g] = ref_prio[g*PRIO_W +: PRIO_W];
    end

    ref_order_track #(.N_REF(N_REF), .RANK_W(RANK_W)) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (ref_valid),
        .rise     (rise),
        .rank_nxt (rank_nxt)
    );

    ref_best_pick #(
        .N_REF(N_REF), .PRIO_W(PRIO_W), .RANK_W(RANK_W), .IDX_W(IDX_W)
    ) u_pick (
        .valid     (ref_valid),
        .prio      (prio_a),
        .rank      (rank_nxt),
        .found     (found),
        .best_idx  (best_idx),
        .best_prio (best_prio)
    );

    always_comb begin
        sel_dec_e         dec;
        logic             forced;
        logic [IDX_W-1:0] force_idx;
        logic             cur_ok;
        logic [N_REF-1:0] sel_oh;

        st_d      = st_q;
        forced    = (force_code != '0) && (force_code != '1) &&
                    (force_code <= FORCE_W'(N_REF));
        force_idx = IDX_W'(force_code - FORCE_W'(1));
        cur_ok    = st_q.sel_valid && ref_valid[st_q.sel_idx] &&
                    (prio_a[st_q.sel_idx] != '0);

        if (forced)
            dec = DEC_FORCED;
        else if (cur_ok && !(revertive && found &&
                             (best_prio < prio_a[st_q.sel_idx])))
            dec = DEC_KEEP;
        else if (found)
            dec = DEC_BEST;
        else
            dec = DEC_HOLD;

        case (dec)
            DEC_FORCED: begin
                st_d.sel_idx   = force_idx;
                st_d.sel_valid = ref_valid[force_idx];
            end
            DEC_KEEP: begin
                st_d.sel_valid = 1'b1;
            end
            DEC_BEST: begin
                st_d.sel_idx   = best_idx;
                st_d.sel_valid = 1'b1;
            end
            default: begin
                st_d.sel_valid = 1'b0;
            end
        endcase

        sel_oh    = st_d.sel_valid ? (N_REF'(1) << st_d.sel_idx) : '0;
        st_d.flag = (st_q.flag & ~reval_clr) | (rise & ~sel_oh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_idx    = st_q.sel_idx;
    assign sel_valid  = st_q.sel_valid;
    assign reval_flag = st_q.flag;
    assign irq        = |(st_q.flag & ~reval_mask);

endmodule

// File: rtl/ref_selector_chk.sv
module ref_selector_chk #(
    parameter int N_REF   = 6,
    parameter int PRIO_W  = 4,
    parameter int FORCE_W = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_REF-1:0]          ref_valid,
    input logic [N_REF*PRIO_W-1:0]   ref_prio,
    input logic                      revertive,
    input logic [FORCE_W-1:0]        force_code,
    input logic [N_REF-1:0]          reval_clr,
    input logic [$clog2(N_REF)-1:0]  sel_idx,
    input logic                      sel_valid,
    input logic [N_REF-1:0]          reval_flag
);

    localparam int IDX_W = $clog2(N_REF);

    logic                    armed;
    logic [N_REF-1:0]        v_q, clr_q, flag_q;
    logic [N_REF*PRIO_W-1:0] prio_q;
    logic                    rev_q, selv_q;
    logic [FORCE_W-1:0]      code_q;
    logic [IDX_W-1:0]        idx_q, fidx_q;
    logic [PRIO_W-1:0]       cur_prio_q;
    logic                    forced_q, auto_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            v_q    <= '0;
            clr_q  <= '0;
            flag_q <= '0;
            prio_q <= '0;
            rev_q  <= 1'b0;
            selv_q <= 1'b0;
            code_q <= '1;
            idx_q  <= '0;
        end else begin
            armed  <= 1'b1;
            v_q    <= ref_valid;
            clr_q  <= reval_clr;
            flag_q <= reval_flag;
            prio_q <= ref_prio;
            rev_q  <= revertive;
            selv_q <= sel_valid;
            code_q <= force_code;
            idx_q  <= sel_idx;
        end
    end

    always_comb begin
        cur_prio_q = prio_q[idx_q*PRIO_W +: PRIO_W];
        forced_q   = (code_q != '0) && (code_q != '1) &&
                     (code_q <= FORCE_W'(N_REF));
        auto_q     = !forced_q;
        fidx_q     = IDX_W'(code_q - FORCE_W'(1));
    end

    assert_sel_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && sel_valid) |-> v_q[sel_idx]);

    assert_holdover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && auto_q && (v_q == '0)) |-> (!sel_valid && (sel_idx == idx_q)));

    assert_nonrev_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && auto_q && !rev_q && selv_q && v_q[idx_q] && (cur_prio_q != '0))
        |-> (sel_valid && (sel_idx == idx_q)));

    assert_forced_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && forced_q) |-> ((sel_idx == fidx_q) && (sel_valid == v_q[fidx_q])));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((reval_flag & flag_q & ~clr_q) == (flag_q & ~clr_q)));

endmodule

bind ref_selector ref_selector_chk #(
    .N_REF(N_REF), .PRIO_W(PRIO_W), .FORCE_W(FORCE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_valid  (ref_valid),
    .ref_prio   (ref_prio),
    .revertive  (revertive),
    .force_code (force_code),
    .reval_clr  (reval_clr),
    .sel_idx    (sel_idx),
    .sel_valid  (sel_valid),
    .reval_flag (reval_flag)
);

// File: tb/sim_ref_selector.sv
`timescale 1ns/1ps
module sim_ref_selector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ref_valid = '0;
    logic [23:0] ref_prio;
    logic        revertive = 1'b1;
    logic [3:0]  force_code = 4'hF;
    logic [5:0]  reval_mask = '0;
    logic [5:0]  reval_clr = '0;
    logic [2:0]  sel_idx;
    logic        sel_valid;
    logic [5:0]  reval_flag;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // in5..in0 priorities = 12, 9, 0, 7, 3, 5
    localparam logic [23:0] PRIO_BASE = {4'd12, 4'd9, 4'd0, 4'd7, 4'd3, 4'd5};
    // in2, in4, in5 share priority 4
    localparam logic [23:0] PRIO_TIE  = {4'd4, 4'd4, 4'd0, 4'd4, 4'd3, 4'd5};

    always #2 clk = ~clk;

    ref_selector u0 (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_prio(ref_prio),
        .revertive(revertive), .force_code(force_code), .reval_mask(reval_mask),
        .reval_clr(reval_clr), .sel_idx(sel_idx), .sel_valid(sel_valid),
        .reval_flag(reval_flag), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] v);
        ref_valid = v;
        tick();
    endtask

    task automatic clear_flags();
        reval_clr = 6'h3F;
        tick();
        reval_clr = '0;
    endtask

    task automatic t_reset();
        chk("R1", "sel_valid", sel_valid, 0);
        chk("R1", "sel_idx", sel_idx, 0);
        chk("R1", "reval_flag", reval_flag, 0);
        chk("R1", "irq", irq, 0);
    endtask

    task automatic t_auto();
        drive(6'b110111);
        chk("R2", "sel_idx best", sel_idx, 1);
        chk("R2", "sel_valid", sel_valid, 1);
        chk("R9", "flags on first rise", reval_flag, 6'b110101);
        chk("R10", "irq unmasked", irq, 1);
        reval_mask = 6'h3F;
        #1;
        chk("R10", "irq masked", irq, 0);
        reval_mask = '0;
        clear_flags();
        chk("R9", "flags cleared", reval_flag, 0);
    endtask

    task automatic t_failover();
        revertive = 1'b1;
        drive(6'b110101);
        chk("R4", "fail in1 -> in0", sel_idx, 0);
        drive(6'b110100);
        chk("R4", "fail in0 -> in2", sel_idx, 2);
        drive(6'b110000);
        chk("R4", "fail in2 -> in4", sel_idx, 4);
        chk("R4", "still live", sel_valid, 1);
    endtask

    task automatic t_revert();
        revertive = 1'b1;
        drive(6'b110100);
        chk("R6", "revert to in2", sel_idx, 2);
        chk("R9", "no flag for chosen", reval_flag, 0);
    endtask

    task automatic t_nonrev();
        revertive = 1'b0;
        drive(6'b110101);
        chk("R5", "hold in2", sel_idx, 2);
        chk("R9", "flag in0", reval_flag, 6'b000001);
        chk("R10", "irq on flag", irq, 1);
        clear_flags();
        // Same cycle: selected in2 fails, better in1 returns.
        drive(6'b110011);
        chk("R4", "failover to in1", sel_idx, 1);
        chk("R9", "no flag for in1", reval_flag, 0);
        revertive = 1'b1;
    endtask

    task automatic t_exclude();
        drive(6'b001000);
        chk("R3", "prio0 not live", sel_valid, 0);
        chk("R8", "idx held", sel_idx, 1);
        drive(6'b000000);
        chk("R8", "holdover valid", sel_valid, 0);
        chk("R8", "holdover idx", sel_idx, 1);
        clear_flags();
    endtask

    task automatic t_fifo();
        ref_prio  = PRIO_TIE;
        revertive = 1'b1;
        drive(6'b100000);
        chk("R11", "first in5", sel_idx, 5);
        drive(6'b100100);
        chk("R11", "in2 equal no switch", sel_idx, 5);
        drive(6'b110100);
        chk("R11", "in4 equal no switch", sel_idx, 5);
        drive(6'b010100);
        chk("R11", "oldest in2 next", sel_idx, 2);
        drive(6'b110100);
        chk("R11", "return in5 no switch", sel_idx, 2);
        drive(6'b110000);
        chk("R11", "in4 older than in5", sel_idx, 4);
        drive(6'b000000);
        drive(6'b110000);
        chk("R11", "same cycle lower idx", sel_idx, 4);
        ref_prio = PRIO_BASE;
        clear_flags();
    endtask

    task automatic t_force();
        drive(6'b110111);
        chk("R2", "auto again in1", sel_idx, 1);
        force_code = 4'd3;
        tick();
        chk("R7", "force in2 idx", sel_idx, 2);
        chk("R7", "force in2 live", sel_valid, 1);
        force_code = 4'd4;
        tick();
        chk("R7", "force in3 idx", sel_idx, 3);
        chk("R7", "force in3 invalid", sel_valid, 0);
        force_code = 4'd6;
        tick();
        chk("R7", "force in5", sel_idx, 5);
        force_code = 4'd9;
        tick();
        chk("R7", "code 9 auto", sel_idx, 1);
        force_code = 4'd6;
        tick();
        force_code = 4'd0;
        tick();
        chk("R7", "code 0 auto", sel_idx, 1);
        force_code = 4'd6;
        tick();
        force_code = 4'hF;
        tick();
        chk("R7", "code 15 auto", sel_idx, 1);
        clear_flags();
    endtask

    task automatic t_sticky();
        drive(6'b110110);
        clear_flags();
        reval_clr = 6'b000001;
        drive(6'b110111);
        reval_clr = '0;
        chk("R9", "set beats clear", reval_flag, 6'b000001);
        chk("R5", "in1 kept", sel_idx, 1);
        tick();
        chk("R9", "sticky", reval_flag, 6'b000001);
        reval_clr = 6'b000001;
        tick();
        reval_clr = '0;
        chk("R9", "cleared", reval_flag, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        ref_prio = PRIO_BASE;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_auto();
        t_failover();
        t_revert();
        t_nonrev();
        t_exclude();
        t_fifo();
        t_force();
        t_sticky();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual 0 expected 1 completion");
            finish_run();
        end
    end

endmodule